// File: doc/BRIEF.md
# FIFO Flag Offset Loader

This block holds the almost-empty and almost-full threshold offsets for a pair of FIFOs, one of each per FIFO, and fills them right after a master reset. The method is chosen by a 3-bit select code. The block samples that code on every clock edge while master reset is high, so the value present at the last reset edge is the one that counts. The code picks one of three methods. A preset method writes one fixed value into all four offsets. A parallel method takes four words from the data port. A serial method clocks a 4×W bit stream in through two of the select pins. In serial mode those pins act as an active-low enable and a data bit.

The four offsets are outputs, together with a done flag. Flag comparators downstream must ignore the offsets while the flag is low. Once the flag is high, the offsets and the flag stay fixed until the next master reset. Select-pin activity and data-port writes have no effect on them after that point.

Top module: `ofl_offset_loader`

## Requirements
- R1: While `rst` is high, every clock edge clears all four offsets to zero and clears `prog_done`.
- R2: The code on `sel` at the last clock edge with `rst` high selects the method. Codes 0, 1, 2, 3 and 4 select presets 8, 16, 64, 256 and 1024. Code 7 selects preset 8. Code 5 selects parallel load and code 6 selects serial load.
- R3: In preset mode, the first clock edge after reset writes the preset value into all four offsets and sets `prog_done` on that same edge.
- R4: In serial mode, `sel[1]` is an active-low shift enable and `sel[0]` is the data bit. Each edge with `sel[1]` low shifts in exactly one bit. An edge with `sel[1]` high changes nothing.
- R5: The serial stream is 4×OFS_W bits long and fills the offsets in the order `y1_ofs`, `x1_ofs`, `y2_ofs`, `x2_ofs`, each MSB first. The first bit ends up as the MSB of `y1_ofs` and the last bit as the LSB of `x2_ofs`.
- R6: `prog_done` rises on the edge that shifts the 4×OFS_W-th serial bit. It stays low after one bit fewer.
- R7: In parallel mode, edges with `wr_en` high store `wr_data` into `y1_ofs`, `x1_ofs`, `y2_ofs` and `x2_ofs` in that order. `prog_done` rises with the fourth write and stays low after three.
- R8: Once `prog_done` is high, it and all four offsets hold their values until the next reset, whatever happens on `sel`, `wr_en` and `wr_data`.
- R9: Inputs that belong to another method have no effect. `wr_en` is ignored in serial and preset modes, and `sel` is ignored after reset in parallel mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock of the programming port |
| rst | input | 1 | Synchronous active-high master reset |
| sel | input | 3 | Method code during reset; afterwards bit 1 = serial enable (active low), bit 0 = serial data |
| wr_en | input | 1 | Parallel word write strobe |
| wr_data | input | OFS_W | Parallel offset word |
| y1_ofs | output | OFS_W | FIFO 1 almost-full offset |
| x1_ofs | output | OFS_W | FIFO 1 almost-empty offset |
| y2_ofs | output | OFS_W | FIFO 2 almost-full offset |
| x2_ofs | output | OFS_W | FIFO 2 almost-empty offset |
| prog_done | output | 1 | Offsets are complete and valid |

## Verification
Every result comes one register stage after its cause. A preset value and the done flag appear after the first edge following reset release. A serial bit or parallel word shows up after the edge that samples it. The bench changes inputs on the falling edge and reads outputs on the next falling edge, so exactly one rising edge lies between a stimulus and its check. Each serial bit and each parallel word is followed by an idle cycle, so the check before done counts exactly 4×OFS_W−1 bits or three words. Stray inputs after done are checked one cycle after they are applied.

// File: rtl/ofl_pkg.sv
package ofl_pkg;

  // number of offset registers (two FIFOs, one X and one Y each)
  localparam int OFL_NREG = 4;

  typedef enum logic [1:0] {
    OFL_PRESET   = 2'd0,
    OFL_PARALLEL = 2'd1,
    OFL_SERIAL   = 2'd2
  } ofl_mode_e;

  function automatic ofl_mode_e mode_of(input logic [2:0] code);
    case (code)
      3'd5:    return OFL_PARALLEL;
      3'd6:    return OFL_SERIAL;
      default: return OFL_PRESET;
    endcase
  endfunction

  function automatic int unsigned preset_of(input logic [2:0] code);
    case (code)
      3'd0:    return 8;
      3'd1:    return 16;
      3'd2:    return 64;
      3'd3:    return 256;
      3'd4:    return 1024;
      default: return 8;
    endcase
  endfunction

endpackage

// File: rtl/ofl_mode_latch.sv
module ofl_mode_latch #(
  parameter int OFS_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          sel,
  output ofl_pkg::ofl_mode_e  mode,
  output logic [OFS_W-1:0]    preset
);
  // sampled on every reset edge; the last one before release sticks
  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= ofl_pkg::mode_of(sel);
      preset <= OFS_W'(ofl_pkg::preset_of(sel));
    end
  end
endmodule

// File: rtl/ofl_serial_ctl.sv
module ofl_serial_ctl #(
  parameter int OFS_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic sen_n,
  output logic shift_en,
  output logic last
);
  localparam int NBITS = ofl_pkg::OFL_NREG * OFS_W;
  localparam int CW    = $clog2(NBITS);

  logic [CW-1:0] cnt_q;

  assign shift_en = arm && !sen_n;
  assign last     = shift_en && (cnt_q == CW'(NBITS - 1));

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (shift_en) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ofl_par_ctl.sv
module ofl_par_ctl (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          arm,
  input  logic                          wr_en,
  output logic [ofl_pkg::OFL_NREG-1:0]  slot_we,
  output logic                          last
);
  localparam int NREG = ofl_pkg::OFL_NREG;
  localparam int SW   = $clog2(NREG);

  logic [SW-1:0] slot_q;
  logic          fire;

  assign fire = arm && wr_en;
  assign last = fire && (slot_q == SW'(NREG - 1));

  for (genvar g = 0; g < NREG; g++) begin : g_we
    assign slot_we[g] = fire && (slot_q == SW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst)       slot_q <= '0;
    else if (fire) slot_q <= slot_q + 1'b1;
  end
endmodule

// File: rtl/ofl_offset_loader.sv
module ofl_offset_loader #(
  parameter int OFS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       sel,
  input  logic             wr_en,
  input  logic [OFS_W-1:0] wr_data,
  output logic [OFS_W-1:0] y1_ofs,
  output logic [OFS_W-1:0] x1_ofs,
  output logic [OFS_W-1:0] y2_ofs,
  output logic [OFS_W-1:0] x2_ofs,
  output logic             prog_done
);
  import ofl_pkg::*;

  localparam int NREG = OFL_NREG;
  localparam int TW   = NREG * OFS_W;

  ofl_mode_e          mode_q;
  logic [OFS_W-1:0]   preset_w;
  logic [TW-1:0]      chain_q;   // slot 0 (y1) sits at the top
  logic               done_q;
  logic               ser_shift, ser_last, par_last, preset_go;
  logic [NREG-1:0]    slot_we;

  ofl_mode_latch #(.OFS_W(OFS_W)) u_mode (
    .clk(clk), .rst(rst), .sel(sel), .mode(mode_q), .preset(preset_w)
  );

  ofl_serial_ctl #(.OFS_W(OFS_W)) u_ser (
    .clk(clk), .rst(rst),
    .arm(!done_q && mode_q == OFL_SERIAL),
    .sen_n(sel[1]), .shift_en(ser_shift), .last(ser_last)
  );

  ofl_par_ctl u_par (
    .clk(clk), .rst(rst),
    .arm(!done_q && mode_q == OFL_PARALLEL),
    .wr_en(wr_en), .slot_we(slot_we), .last(par_last)
  );

  assign preset_go = !done_q && mode_q == OFL_PRESET;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      done_q  <= 1'b0;
    end else begin
      if (preset_go) begin
        chain_q <= {NREG{preset_w}};
      end else if (ser_shift) begin
        chain_q <= {chain_q[TW-2:0], sel[0]};
      end else begin
        for (int i = 0; i < NREG; i++)
          if (slot_we[i]) chain_q[(NREG-1-i)*OFS_W +: OFS_W] <= wr_data;
      end
      if (preset_go || ser_last || par_last) done_q <= 1'b1;
    end
  end

  logic [OFS_W-1:0] slot_v [NREG];
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    assign slot_v[g] = chain_q[(NREG-1-g)*OFS_W +: OFS_W];
  end

  assign y1_ofs    = slot_v[0];
  assign x1_ofs    = slot_v[1];
  assign y2_ofs    = slot_v[2];
  assign x2_ofs    = slot_v[3];
  assign prog_done = done_q;
endmodule

// File: rtl/ofl_offset_loader_chk.sv
module ofl_offset_loader_chk #(
  parameter int OFS_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [2:0]         sel,
  input logic               wr_en,
  input logic [OFS_W-1:0]   y1_ofs,
  input logic [OFS_W-1:0]   x1_ofs,
  input logic [OFS_W-1:0]   y2_ofs,
  input logic [OFS_W-1:0]   x2_ofs,
  input logic               prog_done,
  input ofl_pkg::ofl_mode_e mode
);
  import ofl_pkg::*;

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!prog_done && y1_ofs == '0 && x1_ofs == '0 && y2_ofs == '0 && x2_ofs == '0));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> prog_done);

  // R8
  ofs_stable_chk: assert property (@(posedge clk) disable iff (rst)
    prog_done |=> $stable({y1_ofs, x1_ofs, y2_ofs, x2_ofs}));

  // R3
  preset_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!prog_done && mode == OFL_PRESET) |=> prog_done);

  // R3
  preset_equal_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_done && mode == OFL_PRESET) |-> (y1_ofs == x1_ofs && y1_ofs == y2_ofs && y1_ofs == x2_ofs));

  // R7
  par_done_src_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(prog_done) && mode == OFL_PARALLEL) |-> $past(wr_en));

  // R4
  ser_done_src_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(prog_done) && mode == OFL_SERIAL) |-> !$past(sel[1]));
endmodule

bind ofl_offset_loader ofl_offset_loader_chk #(.OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en),
  .y1_ofs(y1_ofs), .x1_ofs(x1_ofs), .y2_ofs(y2_ofs), .x2_ofs(x2_ofs),
  .prog_done(prog_done), .mode(mode_q)
);

// File: tb/ofl_offset_loader_test.sv
`timescale 1ns/1ps
module ofl_offset_loader_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   sel = 3'b110;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] y1_ofs, x1_ofs, y2_ofs, x2_ofs;
  logic         prog_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ofl_offset_loader #(.OFS_W(W)) uut (
    .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en), .wr_data(wr_data),
    .y1_ofs(y1_ofs), .x1_ofs(x1_ofs), .y2_ofs(y2_ofs), .x2_ofs(x2_ofs),
    .prog_done(prog_done)
  );

  // {code, expected preset}
  localparam logic [18:0] PRESET_VEC [6] = '{
    {3'd0, 16'd8}, {3'd1, 16'd16}, {3'd2, 16'd64},
    {3'd3, 16'd256}, {3'd4, 16'd1024}, {3'd7, 16'd8}
  };

  localparam logic [4*W-1:0] SER_WORD = {16'hA5C3, 16'h1234, 16'hBEEF, 16'h0F0F};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FIFO-offset FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [W-1:0] y1, input logic [W-1:0] x1,
                           input logic [W-1:0] y2, input logic [W-1:0] x2, input logic dn);
    check({req, " y1"}, 32'(y1_ofs), 32'(y1));
    check({req, " x1"}, 32'(x1_ofs), 32'(x1));
    check({req, " y2"}, 32'(y2_ofs), 32'(y2));
    check({req, " x2"}, 32'(x2_ofs), 32'(x2));
    check({req, " done"}, 32'(prog_done), 32'(dn));
  endtask

  // reset with a code; returns at the negedge where rst is released
  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst = 1'b1; sel = code; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1 in reset", '0, '0, '0, '0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sel = {1'b1, 1'b0, b};
    @(negedge clk); sel = 3'b111;
  endtask

  task automatic put_word(input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FIFO-offset FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2 / R3: preset table walk
    for (int i = 0; i < 6; i++) begin
      logic [2:0]   code;
      logic [W-1:0] val;
      code = PRESET_VEC[i][18:16];
      val  = PRESET_VEC[i][15:0];
      do_reset(code);
      @(negedge clk);
      check_all("R2 R3 preset", val, val, val, val, 1'b1);
    end

    // R8 / R9: preset mode ignores later writes and select activity
    put_word(16'hFFFF);
    send_bit(1'b1);
    check_all("R8 R9 preset hold", 16'd8, 16'd8, 16'd8, 16'd8, 1'b1);

    // R4 / R5 / R6: serial stream with idle edges between bits
    do_reset(3'd6);
    @(negedge clk);
    check("R4 serial idle done", 32'(prog_done), 32'd0);
    for (int i = 4*W-1; i >= 0; i--) begin
      if (i == 40) begin
        // R9: parallel strobe ignored in serial mode
        @(negedge clk); wr_en = 1'b1; wr_data = 16'hFFFF; sel = 3'b111;
        @(negedge clk); wr_en = 1'b0;
      end
      send_bit(SER_WORD[i]);
      if (i == 4*W-1) check("R5 first bit lsb", 32'(x2_ofs), 32'(SER_WORD[4*W-1]));
      if (i == 1) check("R6 done low after 4W-1 bits", 32'(prog_done), 32'd0);
    end
    check_all("R5 R6 serial result", 16'hA5C3, 16'h1234, 16'hBEEF, 16'h0F0F, 1'b1);
    // R8: further bits ignored
    send_bit(1'b1);
    send_bit(1'b0);
    check_all("R8 serial hold", 16'hA5C3, 16'h1234, 16'hBEEF, 16'h0F0F, 1'b1);

    // R7: parallel load
    do_reset(3'd5);
    @(negedge clk);
    check("R7 parallel start done", 32'(prog_done), 32'd0);
    // R9: serial pins ignored in parallel mode
    send_bit(1'b1);
    check_all("R9 parallel ignores sel", '0, '0, '0, '0, 1'b0);
    put_word(16'h0111);
    put_word(16'h0222);
    put_word(16'h0333);
    check_all("R7 three words", 16'h0111, 16'h0222, 16'h0333, 16'h0000, 1'b0);
    put_word(16'h0444);
    check_all("R7 four words", 16'h0111, 16'h0222, 16'h0333, 16'h0444, 1'b1);
    put_word(16'h0555);
    check_all("R8 parallel hold", 16'h0111, 16'h0222, 16'h0333, 16'h0444, 1'b1);

    // R1: reset after programming clears everything
    do_reset(3'd2);
    @(negedge clk);
    check_all("R2 reprogram preset", 16'd64, 16'd64, 16'd64, 16'd64, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule